// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block regulates the current in one motor winding driven by a full H-bridge. While enabled, it drives one diagonal pair of switches, chosen by the direction bit. When an external comparator reports that the winding current has reached its threshold, the block switches the bridge into slow decay, with both low-side switches on. It holds that state for a fixed off-time and then drives again.

A blanking window after every drive start masks comparator glitches caused by switching. Every change from the high-side to the low-side switch of one half-bridge, or back, passes through a dead interval in which both switches are off. A two-bit torque code scales the threshold reference code that the block presents to the comparator's reference source.

All times are counted in clock cycles derived from a nominal 100 ns clock period. The off-time, blanking and dead-time values are parameters.

Top module: `fot_chopper`

## Requirements
- R1: While reset is asserted, and after its release with `en` low, all four gate outputs are 0.
- R2: When `en` is 0 at a clock edge, all four gate outputs are 0 from that edge on and the chopper returns to idle. A later rising `en` starts a fresh drive period that begins with blanking.
- R3: In the drive phase with `dir`=1, `a_hi` and `b_lo` are on. With `dir`=0, `b_hi` and `a_lo` are on. From idle, the gates turn on two cycles after `en` is set.
- R4: In the first B cycles of each drive phase, `trip` is ignored. B is 18, 15, 12 or 9 cycles for `blank_sel` = 00, 01, 10, 11. With `trip` held high from idle, the first `a_hi` pulse lasts B+1 cycles.
- R5: A `trip` seen after blanking puts the bridge in slow decay for T cycles: both low-side gates on and both high-side gates off. T is 200 cycles for `toff_sel`=00 (low), 300 cycles for 01 (high), and 100 cycles for 10 or 11 (high-impedance). When leaving the drive with `dir`=1, `a_lo` is on for T-2 cycles because of the dead time.
- R6: At the end of the off-time, drive resumes and a new blanking window starts. With `trip` held high, the next `a_hi` pulse lasts B-1 cycles.
- R7: A half-bridge never has both gates on. A change from its high gate to its low gate, or back, keeps both gates off for exactly 2 cycles.
- R8: `ref_code` is 500, 375, 250 or 125 for `trq` = 00, 01, 10, 11 (bit 1 is the upper torque bit). It follows `trq` combinationally.
- R9: `blank_sel` is sampled when a drive phase starts, and `toff_sel` when a decay phase starts. Changing either in mid-phase does not alter the length of that phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, nominally 10 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Chopper enable |
| dir | input | 1 | Drive diagonal select |
| trip | input | 1 | Current comparator trip flag |
| trq | input | 2 | Torque scaling code |
| toff_sel | input | 2 | Off-time select: 00 low, 01 high, 1x high-impedance |
| blank_sel | input | 2 | Blanking-time select |
| a_hi | output | 1 | Half-bridge A high-side gate |
| a_lo | output | 1 | Half-bridge A low-side gate |
| b_hi | output | 1 | Half-bridge B high-side gate |
| b_lo | output | 1 | Half-bridge B low-side gate |
| ref_code | output | REF_W (9) | Scaled trip reference in millivolts |

## Verification
The bench builds the block with its default parameters: a 100 ns period, 100, 200 and 300-cycle off-times, 9 to 18-cycle blanking and a 2-cycle dead time. With these values, every off-time setting and every blanking setting fits in a few hundred cycles, so all of them can be measured directly as pulse widths. Random phases toggle `trip`, `dir`, `en` and both selects in mid-phase. These reach dead-time interruptions, aborted decays and re-entries from idle, and a cycle model of the requirements follows them.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DRIVE = 2'd1,
    PH_DECAY = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    LEG_OFF  = 2'd0,
    LEG_HIGH = 2'd1,
    LEG_LOW  = 2'd2
  } leg_e;
endpackage

// File: rtl/leg_deadtime.sv
module leg_deadtime
  import chop_pkg::*;
#(
  parameter int DEAD_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  leg_e want,
  output logic hi_on,
  output logic lo_on
);
  localparam int GW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;

  leg_e          cur_q, cur_d;
  logic [GW-1:0] gap_q, gap_d;
  logic          upd;

  always_comb begin
    cur_d = cur_q;
    gap_d = gap_q;
    if (kill || want == LEG_OFF) begin
      cur_d = LEG_OFF;
      gap_d = '0;
    end else if (want == cur_q) begin
      gap_d = '0;
    end else if (cur_q != LEG_OFF) begin
      cur_d = LEG_OFF;
      gap_d = GW'(DEAD_CYC - 1);
    end else if (gap_q != '0) begin
      gap_d = gap_q - 1'b1;
    end else begin
      cur_d = want;
    end
  end

  assign upd = (cur_d != cur_q) || (gap_d != gap_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= LEG_OFF;
      gap_q <= '0;
    end else if (upd) begin
      cur_q <= cur_d;
      gap_q <= gap_d;
    end
  end

  assign hi_on = (cur_q == LEG_HIGH);
  assign lo_on = (cur_q == LEG_LOW);

  // R7
  no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_on && lo_on));
  // R7
  hi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_on |=> !lo_on);
  // R7
  lo_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_on |=> !hi_on);
  // R2
  kill_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (!hi_on && !lo_on));
endmodule

// File: rtl/chop_sequencer.sv
module chop_sequencer
  import chop_pkg::*;
#(
  parameter int BLANK_LONG_CYC = 18,
  parameter int BLANK_STEP_CYC = 3,
  parameter int TOFF_LO_CYC    = 200,
  parameter int TOFF_HI_CYC    = 300,
  parameter int TOFF_Z_CYC     = 100,
  parameter int CW             = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       trip,
  input  logic [1:0] blank_sel,
  input  logic [1:0] toff_sel,
  output phase_e     phase
);
  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] blank_len, toff_len_m1;
  logic          upd;

  assign blank_len = CW'(BLANK_LONG_CYC - BLANK_STEP_CYC * int'(blank_sel));

  always_comb begin
    case (toff_sel)
      2'b00:   toff_len_m1 = CW'(TOFF_LO_CYC - 1);
      2'b01:   toff_len_m1 = CW'(TOFF_HI_CYC - 1);
      default: toff_len_m1 = CW'(TOFF_Z_CYC - 1);
    endcase
  end

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (!en) begin
      ph_d  = PH_IDLE;
      cnt_d = '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          ph_d  = PH_DRIVE;
          cnt_d = blank_len;
        end
        PH_DRIVE: begin
          if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
          end else if (trip) begin
            ph_d  = PH_DECAY;
            cnt_d = toff_len_m1;
          end
        end
        PH_DECAY: begin
          if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
          end else begin
            ph_d  = PH_DRIVE;
            cnt_d = blank_len;
          end
        end
        default: begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  assign upd = (ph_d != ph_q) || (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else if (upd) begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign phase = ph_q;

  // R4
  blank_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DRIVE && cnt_q != '0) |=> (ph_q != PH_DECAY));
  // R5
  decay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DECAY && cnt_q != '0 && en) |=> (ph_q == PH_DECAY));
  // R6
  resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DECAY && cnt_q == '0 && en) |=> (ph_q == PH_DRIVE));
  // R2
  idle_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (ph_q == PH_IDLE));
endmodule

// File: rtl/fot_chopper.sv
module fot_chopper
  import chop_pkg::*;
#(
  parameter int CLK_NS        = 100,
  parameter int TOFF_LO_NS    = 20000,
  parameter int TOFF_HI_NS    = 30000,
  parameter int TOFF_Z_NS     = 10000,
  parameter int BLANK_LONG_NS = 1800,
  parameter int BLANK_STEP_NS = 300,
  parameter int DEAD_NS       = 200,
  parameter int FULL_MV       = 500,
  parameter int REF_W         = $clog2(FULL_MV + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             dir,
  input  logic             trip,
  input  logic [1:0]       trq,
  input  logic [1:0]       toff_sel,
  input  logic [1:0]       blank_sel,
  output logic             a_hi,
  output logic             a_lo,
  output logic             b_hi,
  output logic             b_lo,
  output logic [REF_W-1:0] ref_code
);
  localparam int TOFF_LO_CYC    = TOFF_LO_NS / CLK_NS;
  localparam int TOFF_HI_CYC    = TOFF_HI_NS / CLK_NS;
  localparam int TOFF_Z_CYC     = TOFF_Z_NS / CLK_NS;
  localparam int BLANK_LONG_CYC = BLANK_LONG_NS / CLK_NS;
  localparam int BLANK_STEP_CYC = BLANK_STEP_NS / CLK_NS;
  localparam int DEAD_CYC       = DEAD_NS / CLK_NS;
  localparam int TOFF_MAX_A     = (TOFF_LO_CYC > TOFF_HI_CYC) ? TOFF_LO_CYC : TOFF_HI_CYC;
  localparam int TOFF_MAX       = (TOFF_MAX_A > TOFF_Z_CYC) ? TOFF_MAX_A : TOFF_Z_CYC;
  localparam int CNT_MAX        = (TOFF_MAX > BLANK_LONG_CYC) ? TOFF_MAX : BLANK_LONG_CYC;
  localparam int CW             = $clog2(CNT_MAX + 1);

  logic [1:0] rst_pipe;
  logic       srst_n;
  phase_e     phase;
  logic [1:0] hi_v, lo_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  chop_sequencer #(
    .BLANK_LONG_CYC(BLANK_LONG_CYC),
    .BLANK_STEP_CYC(BLANK_STEP_CYC),
    .TOFF_LO_CYC   (TOFF_LO_CYC),
    .TOFF_HI_CYC   (TOFF_HI_CYC),
    .TOFF_Z_CYC    (TOFF_Z_CYC),
    .CW            (CW)
  ) i_seq (
    .clk      (clk),
    .rst_n    (srst_n),
    .en       (en),
    .trip     (trip),
    .blank_sel(blank_sel),
    .toff_sel (toff_sel),
    .phase    (phase)
  );

  for (genvar g = 0; g < 2; g++) begin : g_leg
    localparam logic HIGH_WHEN = (g == 0) ? 1'b1 : 1'b0;
    leg_e want;

    always_comb begin
      case (phase)
        PH_DRIVE: want = (dir == HIGH_WHEN) ? LEG_HIGH : LEG_LOW;
        PH_DECAY: want = LEG_LOW;
        default:  want = LEG_OFF;
      endcase
    end

    leg_deadtime #(.DEAD_CYC(DEAD_CYC)) i_leg (
      .clk  (clk),
      .rst_n(srst_n),
      .kill (~en),
      .want (want),
      .hi_on(hi_v[g]),
      .lo_on(lo_v[g])
    );
  end

  assign a_hi = hi_v[0];
  assign a_lo = lo_v[0];
  assign b_hi = hi_v[1];
  assign b_lo = lo_v[1];

  assign ref_code = REF_W'((FULL_MV * (4 - int'(trq))) / 4);
endmodule

// File: tb/test_fot_chopper.sv
module test_fot_chopper;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, dir = 1'b1, trip = 1'b0;
  logic [1:0] trq = 2'b00, toff_sel = 2'b00, blank_sel = 2'b00;
  logic       a_hi, a_lo, b_hi, b_lo;
  logic [8:0] ref_code;
  int tests = 0, fails = 0;
  bit cmp_on = 1'b0;

  fot_chopper i_fot_chopper (
    .clk(clk), .rst_n(rst_n), .en(en), .dir(dir), .trip(trip), .trq(trq),
    .toff_sel(toff_sel), .blank_sel(blank_sel), .a_hi(a_hi), .a_lo(a_lo),
    .b_hi(b_hi), .b_lo(b_lo), .ref_code(ref_code)
  );

  always #2 clk = ~clk;

  function automatic int blank_cyc(logic [1:0] s); return 18 - 3 * int'(s); endfunction
  function automatic int toff_cyc(logic [1:0] s);
    if (s == 2'b00) return 200;
    if (s == 2'b01) return 300;
    return 100;
  endfunction
  function automatic int ref_exp(logic [1:0] t); return (500 * (4 - int'(t))) / 4; endfunction
  // leg wish: 0 off, 1 high, 2 low; phase: 0 idle, 1 drive, 2 decay
  function automatic int wish(int leg, int ph, logic d);
    if (ph == 0) return 0;
    if (ph == 2) return 2;
    return ((leg == 0) == (d == 1'b1)) ? 1 : 2;
  endfunction

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // cycle model of the requirements
  int m_ph, m_left, m_leg[2], m_wait[2];
  always @(posedge clk or negedge rst_n) begin
    int w;
    if (!rst_n) begin
      m_ph = 0; m_left = 0;
      m_leg[0] = 0; m_leg[1] = 0; m_wait[0] = 0; m_wait[1] = 0;
    end else begin
      for (int h = 0; h < 2; h++) begin
        w = wish(h, m_ph, dir);
        if (!en || w == 0) begin m_leg[h] = 0; m_wait[h] = 0; end
        else if (w == m_leg[h]) m_wait[h] = 0;
        else if (m_leg[h] != 0) begin m_leg[h] = 0; m_wait[h] = 1; end
        else if (m_wait[h] > 0) m_wait[h]--;
        else m_leg[h] = w;
      end
      if (!en) begin m_ph = 0; m_left = 0; end
      else if (m_ph == 0) begin m_ph = 1; m_left = blank_cyc(blank_sel); end
      else if (m_left > 0) m_left--;
      else if (m_ph == 1) begin
        if (trip) begin m_ph = 2; m_left = toff_cyc(toff_sel) - 1; end
      end else begin m_ph = 1; m_left = blank_cyc(blank_sel); end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      int exp_v;
      exp_v = {29'd0, m_leg[0] == 1, m_leg[0] == 2, m_leg[1] == 1, m_leg[1] == 2};
      check(m_ph == 0 ? "R2 gates idle" : (m_ph == 2 ? "R5 decay gates" : "R3/R7 drive gates"),
            {29'd0, a_hi, a_lo, b_hi, b_lo}, exp_v);
      if (a_hi && a_lo) check("R7 leg A overlap", 1, 0);
      if (b_hi && b_lo) check("R7 leg B overlap", 1, 0);
    end
  end

  function automatic logic sig(int which); return (which == 0) ? a_hi : a_lo; endfunction

  task automatic pulse_len(int which, output int len);
    int guard;
    guard = 0; len = 0;
    while (!sig(which) && guard < 2000) begin @(negedge clk); guard++; end
    while (sig(which) && guard < 2000) begin len++; @(negedge clk); guard++; end
  endtask

  task automatic go_idle();
    en = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(4 * 190000);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int len;
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    check("R1 gates in reset", {a_hi, a_lo, b_hi, b_lo}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 gates after release", {a_hi, a_lo, b_hi, b_lo}, 0);
    cmp_on = 1'b1;

    for (int q = 0; q < 4; q++) begin // R8
      trq = 2'(q); #1;
      check("R8 ref_code", int'(ref_code), ref_exp(2'(q)));
    end

    for (int s = 0; s < 4; s++) begin // R4
      go_idle();
      dir = 1'b1; trip = 1'b1; blank_sel = 2'(s); toff_sel = 2'b10; en = 1'b1;
      pulse_len(0, len);
      check("R4 first drive pulse", len, blank_cyc(2'(s)) + 1);
    end

    for (int t = 0; t < 4; t++) begin // R5, R6
      go_idle();
      dir = 1'b1; trip = 1'b1; blank_sel = 2'b00; toff_sel = 2'(t); en = 1'b1;
      pulse_len(0, len);
      pulse_len(1, len);
      check("R5 decay low-side width", len, toff_cyc(2'(t)) - 2);
      pulse_len(0, len);
      check("R6 resumed drive pulse", len, blank_cyc(2'b00) - 1);
    end

    go_idle(); // R9
    dir = 1'b1; trip = 1'b1; blank_sel = 2'b00; toff_sel = 2'b01; en = 1'b1;
    @(negedge clk);
    blank_sel = 2'b11;
    pulse_len(0, len);
    check("R9 blank_sel change mid-drive", len, 19);
    toff_sel = 2'b10;
    pulse_len(1, len);
    check("R9 toff_sel change mid-decay", len, 298);

    go_idle(); // R3
    dir = 1'b0; trip = 1'b0; en = 1'b1;
    @(negedge clk);
    check("R3 no gate one cycle after en", {a_hi, a_lo, b_hi, b_lo}, 0);
    @(negedge clk);
    check("R3 dir=0 diagonal", {a_hi, a_lo, b_hi, b_lo}, 4'b0110);

    dir = 1'b1; // R7
    @(negedge clk);
    check("R7 dead cycle 1", {a_hi, a_lo, b_hi, b_lo}, 0);
    @(negedge clk);
    check("R7 dead cycle 2", {a_hi, a_lo, b_hi, b_lo}, 0);
    @(negedge clk);
    check("R7 dir=1 diagonal after dead time", {a_hi, a_lo, b_hi, b_lo}, 4'b1001);

    en = 1'b0; // R2
    @(negedge clk);
    check("R2 gates off after en low", {a_hi, a_lo, b_hi, b_lo}, 0);

    en = 1'b1;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if ($urandom % 150 == 0) en = ~en;
      else if (!en && ($urandom % 8 == 0)) en = 1'b1;
      if ($urandom % 120 == 0) dir = ~dir;
      trip = ($urandom % 6 == 0);
      if ($urandom % 40 == 0) blank_sel = 2'($urandom);
      if ($urandom % 40 == 0) toff_sel = 2'($urandom);
      if ($urandom % 50 == 0) begin
        trq = 2'($urandom); #1;
        check("R8 ref_code random", int'(ref_code), ref_exp(trq));
      end
    end

    cmp_on = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule